// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the sequencing datapath of one DMA channel. It keeps the current source address, the destination address and the remaining byte count, and a reload copy of each. A read-beat strobe marks each transfer read into the channel FIFO: the source address steps forward and the count steps down. A write-beat strobe marks each transfer written out of the FIFO: the destination address steps forward. Each side has its own beat width of one, two or four bytes, and the step size follows that width.

When a read beat empties the count, a count-to-zero event fires. If reload is enabled, all three working registers take their reload copies and the channel keeps running. If reload is disabled, the channel turns itself off. Sticky flags record both events, and a level interrupt is formed from the flags and two enables in the control word. Software programs the block through a single-cycle write port with a 3-bit register select.

Top module: `dma_chan_seq`

## Requirements
- R1: After a synchronous active-low reset, every address, count, control and reload register is zero, status_word is zero and irq is low.
- R2: On a read beat while the channel is enabled (control bit 0), the source address advances by the source step if control bit 18 is set, and holds if that bit is clear. The source width code is control bits 17:16: 0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes.
- R3: On a write beat while the channel is enabled, the destination address advances by the destination step if control bit 22 is set, and holds otherwise. The destination width code is control bits 21:20, with the same code-to-step mapping as R2.
- R4: The 24-bit byte count decreases by the source step on every enabled read beat.
- R5: A read beat whose step is greater than or equal to the remaining count, a count of zero included, leaves the count at zero and fires count-to-zero.
- R6: On count-to-zero with reload enabled (control bit 1), the following happens in that cycle. The source and destination addresses take their 31-bit reload values, zero-extended to 32 bits. The count takes the low 24 bits of its reload word. The channel stays enabled. The reload takes precedence over a write-beat step in the same cycle.
- R7: On count-to-zero with reload disabled, control bit 0 and status bit 0 clear. Later beats change nothing until the channel is enabled again.
- R8: Status bit 2 (count-to-zero) and status bit 3 (reload) set on their events and stay set. Writing status with a 1 in a bit clears it. A set in the same cycle as a clear wins. Status bits 4 and 6 always read zero.
- R9: irq is high when status bit 2 is set and either control bit 31 is set, or control bit 30 is set while the channel is disabled. Status bit 1 mirrors irq.
- R10: Register select codes are 0 control, 1 status, 2 source, 3 destination, 4 count, 5 source reload, 6 destination reload, 7 count reload. A write takes effect at the next clock and overrides a beat or a reload on the same register. Writing the count reload word with bit 31 set also sets control bit 0.
- R11: While control bit 0 is clear, read and write beats change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code (R10) |
| reg_wdata | input | 32 | Register write data |
| rd_beat | input | 1 | One beat read into the FIFO |
| wr_beat | input | 1 | One beat written out of the FIFO |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| byte_cnt | output | 24 | Remaining byte count |
| ctrl_word | output | 32 | Control register |
| status_word | output | 32 | Status word |
| irq | output | 1 | Interrupt request level |

## Verification
Four things can land in one cycle: the count-to-zero reload, a write beat stepping the destination address, a software status write that clears a flag, and a register write to a working register. Directed cycles pair them on purpose. One read beat empties the count while a write beat is present, so the reload must win on the destination. A status clear arrives on the cycle the count hits zero, so the flag must stay set. A count write meets a read beat, so the written value must stand. A long random phase then mixes all strobes and writes. After every clock, each output is compared with a behavioural model that applies these precedence rules.

// File: rtl/dma_seq_pkg.sv
// Package: shared codes, field positions and the width-to-step mapping for
// the DMA channel sequencer. Assumes byte-addressed memory.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        BW_BYTE = 2'd0,
        BW_HALF = 2'd1,
        BW_WORD = 2'd2,
        BW_RSVD = 2'd3
    } beat_width_e;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_STAT   = 3'd1,
        SEL_SRC    = 3'd2,
        SEL_DST    = 3'd3,
        SEL_CNT    = 3'd4,
        SEL_SRC_RL = 3'd5,
        SEL_DST_RL = 3'd6,
        SEL_CNT_RL = 3'd7
    } reg_sel_e;

    // control word bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_RLD     = 1;
    localparam int CTL_SW_LO   = 16;
    localparam int CTL_SINC    = 18;
    localparam int CTL_DW_LO   = 20;
    localparam int CTL_DINC    = 22;
    localparam int CTL_HALT_IE = 30;
    localparam int CTL_ZERO_IE = 31;

    // status word bit positions
    localparam int ST_ACT  = 0;
    localparam int ST_PEND = 1;
    localparam int ST_ZERO = 2;
    localparam int ST_RLD  = 3;

    // count reload word: bit that re-arms the channel
    localparam int CRL_ARM = 31;

    // bytes moved by one beat of the given width code (reserved code = word)
    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (beat_width_e'(code))
            BW_BYTE: beat_bytes = 3'd1;
            BW_HALF: beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
// Module: one address register with its reload copy.
// Steps by the beat width when asked, loads from the reload copy on a reload
// event, and takes software writes with top precedence.
// Assumes RW <= AW; a narrower reload copy is zero-extended.
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cur,
    input  logic          wr_rld,
    input  logic [AW-1:0] wr_val,
    input  logic          reload,
    input  logic          adv,
    input  logic [1:0]    width,
    output logic [AW-1:0] addr_o
);
    localparam int PAD = AW - RW;

    logic [AW-1:0] addr_q;
    logic [RW-1:0] rld_q;
    logic [AW-1:0] rld_ext;

    // widen the reload copy to the address width
    generate
        if (PAD > 0) begin : g_pad
            assign rld_ext = {{PAD{1'b0}}, rld_q};
        end else begin : g_nopad
            assign rld_ext = rld_q[AW-1:0];
        end
    endgenerate

    // working address: write, then reload, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_cur) begin
            addr_q <= wr_val;
        end else if (reload) begin
            addr_q <= rld_ext;
        end else if (adv) begin
            addr_q <= addr_q + AW'(beat_bytes(width));
        end
    end

    // reload copy: software write only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_rld) begin
            rld_q <= wr_val[RW-1:0];
        end
    end

    assign addr_o = addr_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cur && !reload && !adv) |=> $stable(addr_o)); // R2

    AST_RELOAD_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_cur && PAD > 0) |=> !addr_o[AW-1]); // R6

endmodule

// File: rtl/dma_count_unit.sv
// Module: remaining byte count with reload copy and zero detection.
// Decrements by the source step per beat and clamps at zero instead of
// wrapping. zero_evt_o is combinational for the current beat.
// Assumes the beat input is already gated by the channel enable.
module dma_count_unit
    import dma_seq_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cur,
    input  logic          wr_rld,
    input  logic [CW-1:0] wr_val,
    input  logic          reload,
    input  logic          beat,
    input  logic [1:0]    width,
    output logic [CW-1:0] cnt_o,
    output logic          zero_evt_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rld_q;
    logic [CW-1:0] step;
    logic          last_beat;

    // step size and whether this beat exhausts the count
    always_comb begin
        step      = CW'(beat_bytes(width));
        last_beat = (cnt_q <= step);
    end

    assign zero_evt_o = beat && last_beat;

    // working count: write, then reload, then clamped decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cur) begin
            cnt_q <= wr_val;
        end else if (reload) begin
            cnt_q <= rld_q;
        end else if (beat) begin
            cnt_q <= last_beat ? '0 : cnt_q - step;
        end
    end

    // reload copy: software write only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_rld) begin
            rld_q <= wr_val;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !wr_cur && !reload) |=> (cnt_o <= $past(cnt_o))); // R4

    AST_ZERO_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt_o && !wr_cur && !reload) |=> (cnt_o == '0)); // R5

endmodule

// File: rtl/dma_flag_unit.sv
// Module: sticky event flags with write-one-to-clear and interrupt forming.
// A set in the same cycle as a clear wins. irq is formed from registered
// flags and the registered control bits.
module dma_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_set,
    input  logic rld_set,
    input  logic clr_zero,
    input  logic clr_rld,
    input  logic zero_ie,
    input  logic halt_ie,
    input  logic chan_en,
    output logic zero_f,
    output logic rld_f,
    output logic irq
);
    // count-to-zero flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_f <= 1'b0;
        end else if (zero_set) begin
            zero_f <= 1'b1;
        end else if (clr_zero) begin
            zero_f <= 1'b0;
        end
    end

    // reload flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_f <= 1'b0;
        end else if (rld_set) begin
            rld_f <= 1'b1;
        end else if (clr_rld) begin
            rld_f <= 1'b0;
        end
    end

    // interrupt: count-to-zero, or count-to-zero that left the channel off
    assign irq = zero_f && (zero_ie || (halt_ie && !chan_en));

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_f && !clr_zero) |=> zero_f); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_set && clr_rld) |=> rld_f); // R8

endmodule

// File: rtl/dma_chan_seq.sv
// Module: DMA channel address and count sequencer (top).
// Holds the control word, decodes the register write port, gates beats with
// the channel enable and wires the address, count and flag units together.
// Assumes at most one register write per cycle; beats are single-cycle strobes.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RLD_W   = 31,
    parameter int CNT_W   = 24,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              rd_beat,
    input  logic              wr_beat,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] status_word,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q;
    logic [NSEL-1:0]   wsel;
    logic              rd_go;
    logic              wr_go;
    logic              zero_evt;
    logic              do_reload;
    logic              zero_f;
    logic              rld_f;

    localparam int NSEL = 8;

    // one-hot decode of the register write port
    generate
        for (genvar i = 0; i < NSEL; i++) begin : g_dec
            assign wsel[i] = reg_we && (reg_sel == 3'(i));
        end
    endgenerate

    // beats only count while the channel is enabled
    always_comb begin
        rd_go     = rd_beat && ctrl_q[CTL_EN];
        wr_go     = wr_beat && ctrl_q[CTL_EN];
        do_reload = zero_evt && ctrl_q[CTL_RLD];
    end

    // control word: auto-stop, re-arm by count reload, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (zero_evt && !ctrl_q[CTL_RLD]) begin
                ctrl_q[CTL_EN] <= 1'b0;
            end
            if (wsel[SEL_CNT_RL] && reg_wdata[CRL_ARM]) begin
                ctrl_q[CTL_EN] <= 1'b1;
            end
            if (wsel[SEL_CTRL]) begin
                ctrl_q <= reg_wdata;
            end
        end
    end

    dma_addr_unit #(.AW(ADDR_W), .RW(RLD_W)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cur (wsel[SEL_SRC]),
        .wr_rld (wsel[SEL_SRC_RL]),
        .wr_val (reg_wdata[ADDR_W-1:0]),
        .reload (do_reload),
        .adv    (rd_go && ctrl_q[CTL_SINC]),
        .width  (ctrl_q[CTL_SW_LO +: 2]),
        .addr_o (src_addr)
    );

    dma_addr_unit #(.AW(ADDR_W), .RW(RLD_W)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cur (wsel[SEL_DST]),
        .wr_rld (wsel[SEL_DST_RL]),
        .wr_val (reg_wdata[ADDR_W-1:0]),
        .reload (do_reload),
        .adv    (wr_go && ctrl_q[CTL_DINC]),
        .width  (ctrl_q[CTL_DW_LO +: 2]),
        .addr_o (dst_addr)
    );

    dma_count_unit #(.CW(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cur     (wsel[SEL_CNT]),
        .wr_rld     (wsel[SEL_CNT_RL]),
        .wr_val     (reg_wdata[CNT_W-1:0]),
        .reload     (do_reload),
        .beat       (rd_go),
        .width      (ctrl_q[CTL_SW_LO +: 2]),
        .cnt_o      (byte_cnt),
        .zero_evt_o (zero_evt)
    );

    dma_flag_unit u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_set (zero_evt),
        .rld_set  (do_reload),
        .clr_zero (wsel[SEL_STAT] && reg_wdata[ST_ZERO]),
        .clr_rld  (wsel[SEL_STAT] && reg_wdata[ST_RLD]),
        .zero_ie  (ctrl_q[CTL_ZERO_IE]),
        .halt_ie  (ctrl_q[CTL_HALT_IE]),
        .chan_en  (ctrl_q[CTL_EN]),
        .zero_f   (zero_f),
        .rld_f    (rld_f),
        .irq      (irq)
    );

    // status word assembly; unused positions read zero
    always_comb begin
        status_word          = '0;
        status_word[ST_ACT]  = ctrl_q[CTL_EN];
        status_word[ST_PEND] = irq;
        status_word[ST_ZERO] = zero_f;
        status_word[ST_RLD]  = rld_f;
    end

    assign ctrl_word = ctrl_q;

    AST_STOP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !ctrl_q[CTL_RLD] && !reg_we) |=> !ctrl_word[CTL_EN]); // R7

    AST_RELOAD_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (do_reload && !reg_we) |=> (ctrl_word[CTL_EN] && status_word[ST_RLD])); // R6

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_EN] && !reg_we) |=> ($stable(byte_cnt) && $stable(src_addr)
                                          && $stable(dst_addr))); // R11

endmodule

// File: tb/sim_dma_chan_seq.sv
// Bench: behavioural reference model stepped once per clock and compared
// with every output of the sequencer after each edge.
module sim_dma_chan_seq;

    localparam int S_CTRL = 0, S_STAT = 1, S_SRC = 2, S_DST = 3,
                   S_CNT = 4, S_SRL = 5, S_DRL = 6, S_CRL = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;
    logic [31:0] src_addr, dst_addr, ctrl_word, status_word;
    logic [23:0] byte_cnt;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    logic [31:0] m_ctrl = 0, m_src = 0, m_dst = 0;
    logic [23:0] m_cnt = 0, m_crl = 0;
    logic [30:0] m_srl = 0, m_drl = 0;
    logic        m_fz = 0, m_fr = 0;

    always #4 clk = ~clk;

    dma_chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_beat(rd_beat), .wr_beat(wr_beat),
        .src_addr(src_addr), .dst_addr(dst_addr), .byte_cnt(byte_cnt),
        .ctrl_word(ctrl_word), .status_word(status_word), .irq(irq)
    );

    function automatic int stepsz(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input string tag, input string fld,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic        e_irq;
        logic [31:0] e_st;
        e_irq = m_fz && (m_ctrl[31] || (m_ctrl[30] && !m_ctrl[0]));
        e_st  = {28'd0, m_fr, m_fz, e_irq, m_ctrl[0]};
        chk(tag, "src_addr", src_addr, m_src);
        chk(tag, "dst_addr", dst_addr, m_dst);
        chk(tag, "byte_cnt", {8'd0, byte_cnt}, {8'd0, m_cnt});
        chk(tag, "ctrl_word", ctrl_word, m_ctrl);
        chk(tag, "status_word", status_word, e_st);
        chk(tag, "irq", {31'd0, irq}, {31'd0, e_irq});
    endtask

    // one clock: drive, advance model, wait for the edge, compare at negedge
    task automatic cyc(input logic we, input int sel, input logic [31:0] d,
                       input logic rb, input logic wb, input string tag);
        logic        en, zero, rel;
        int          ss, ds;
        logic [31:0] n_ctrl, n_src, n_dst;
        logic [23:0] n_cnt;
        logic        n_fz, n_fr;
        reg_we = we; reg_sel = 3'(sel); reg_wdata = d;
        rd_beat = rb; wr_beat = wb;
        en   = m_ctrl[0];
        ss   = stepsz(m_ctrl[17:16]);
        ds   = stepsz(m_ctrl[21:20]);
        zero = en && rb && (int'(m_cnt) <= ss);
        rel  = zero && m_ctrl[1];
        n_src = m_src;
        if (we && sel == S_SRC) n_src = d;
        else if (rel) n_src = {1'b0, m_srl};
        else if (en && rb && m_ctrl[18]) n_src = m_src + 32'(ss);
        n_dst = m_dst;
        if (we && sel == S_DST) n_dst = d;
        else if (rel) n_dst = {1'b0, m_drl};
        else if (en && wb && m_ctrl[22]) n_dst = m_dst + 32'(ds);
        n_cnt = m_cnt;
        if (we && sel == S_CNT) n_cnt = d[23:0];
        else if (rel) n_cnt = m_crl;
        else if (en && rb) n_cnt = zero ? 24'd0 : m_cnt - 24'(ss);
        n_ctrl = m_ctrl;
        if (zero && !m_ctrl[1]) n_ctrl[0] = 1'b0;
        if (we && sel == S_CRL && d[31]) n_ctrl[0] = 1'b1;
        if (we && sel == S_CTRL) n_ctrl = d;
        n_fz = zero ? 1'b1 : (we && sel == S_STAT && d[2]) ? 1'b0 : m_fz;
        n_fr = rel  ? 1'b1 : (we && sel == S_STAT && d[3]) ? 1'b0 : m_fr;
        @(posedge clk);
        @(negedge clk);
        m_ctrl = n_ctrl; m_src = n_src; m_dst = n_dst; m_cnt = n_cnt;
        m_fz = n_fz; m_fr = n_fr;
        if (we && sel == S_SRL) m_srl = d[30:0];
        if (we && sel == S_DRL) m_drl = d[30:0];
        if (we && sel == S_CRL) m_crl = d[23:0];
        compare_all(tag);
    endtask

    task automatic wr(input int sel, input logic [31:0] d, input string tag);
        cyc(1'b1, sel, d, 1'b0, 1'b0, tag);
    endtask

    task automatic beats(input int n, input logic rb, input logic wb, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 32'd0, rb, wb, tag);
    endtask

    // control word builder: en, reload, src width/inc, dst width/inc, ies
    function automatic logic [31:0] cw(input logic en, input logic rl,
                                       input logic [1:0] sw, input logic si,
                                       input logic [1:0] dw, input logic di,
                                       input logic hie, input logic zie);
        logic [31:0] v = 32'd0;
        v[0] = en; v[1] = rl; v[17:16] = sw; v[18] = si;
        v[21:20] = dw; v[22] = di; v[30] = hie; v[31] = zie;
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // R11: programmed but disabled, beats do nothing
        wr(S_SRC, 32'h0000_1000, "R10");
        wr(S_DST, 32'h0000_2000, "R10");
        wr(S_CNT, 32'd40, "R10");
        wr(S_CTRL, cw(0, 0, 0, 1, 0, 1, 0, 0), "R10");
        beats(3, 1'b1, 1'b1, "R11");

        // R2 R3 R4: byte widths, incrementing
        wr(S_CTRL, cw(1, 0, 0, 1, 0, 1, 0, 0), "R10");
        beats(3, 1'b1, 1'b0, "R2");
        beats(2, 1'b0, 1'b1, "R3");
        beats(2, 1'b1, 1'b1, "R4");

        // halfword source, word destination
        wr(S_CTRL, cw(1, 0, 1, 1, 2, 1, 0, 0), "R10");
        beats(3, 1'b1, 1'b1, "R4");

        // increments off: addresses hold, count still falls
        wr(S_CTRL, cw(1, 0, 2, 0, 2, 0, 0, 0), "R10");
        beats(2, 1'b1, 1'b1, "R2");

        // reserved width code 3 steps by four
        wr(S_CTRL, cw(1, 0, 3, 1, 3, 1, 0, 0), "R10");
        beats(1, 1'b1, 1'b1, "R3");

        // R5 R7 R9: word beat over 3 remaining bytes, no reload
        wr(S_CNT, 32'd3, "R10");
        wr(S_CTRL, cw(1, 0, 2, 1, 0, 1, 0, 1), "R10");
        beats(1, 1'b1, 1'b0, "R5");
        beats(3, 1'b1, 1'b1, "R7");
        compare_all("R9");

        // R8: write-one-to-clear, then halt interrupt path
        wr(S_STAT, 32'h0000_0004, "R8");
        wr(S_CNT, 32'd1, "R10");
        wr(S_CTRL, cw(1, 0, 0, 1, 0, 1, 1, 0), "R10");
        beats(1, 1'b1, 1'b0, "R9");
        beats(1, 1'b0, 1'b0, "R9");

        // count already zero still fires and clamps
        wr(S_STAT, 32'h0000_000C, "R8");
        wr(S_CTRL, cw(1, 0, 1, 1, 0, 1, 0, 1), "R10");
        beats(1, 1'b1, 1'b0, "R5");

        // R6: reload, with a write beat landing on the zero cycle
        wr(S_SRL, 32'hFAAA_0000, "R10");
        wr(S_DRL, 32'h0BBB_0010, "R10");
        wr(S_CRL, 32'd4, "R10");
        wr(S_CNT, 32'd2, "R10");
        wr(S_CTRL, cw(1, 1, 0, 1, 0, 1, 0, 1), "R10");
        beats(2, 1'b1, 1'b1, "R6");
        beats(4, 1'b1, 1'b1, "R6");

        // R8: clear and set in the same cycle, set wins
        wr(S_CNT, 32'd1, "R10");
        cyc(1'b1, S_STAT, 32'h0000_000C, 1'b1, 1'b0, "R8");

        // R10: write to count beats a same-cycle read beat
        cyc(1'b1, S_CNT, 32'd100, 1'b1, 1'b0, "R10");

        // R10: stop, then re-arm through the count reload word
        wr(S_CTRL, cw(1, 0, 2, 1, 2, 1, 0, 0), "R10");
        wr(S_CNT, 32'd4, "R10");
        beats(1, 1'b1, 1'b0, "R7");
        wr(S_CRL, 32'h8000_0008, "R10");
        wr(S_CNT, 32'd8, "R10");
        beats(2, 1'b1, 1'b1, "R10");

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic        we;
            int          sel;
            logic [31:0] d;
            we  = ($urandom % 6) == 0;
            sel = $urandom % 8;
            d   = $urandom;
            if (sel == S_CNT || sel == S_CRL) d[23:0] = 24'($urandom % 24);
            if (sel == S_CTRL) d[0] = ($urandom % 4) != 0;
            cyc(we, sel, d, 1'($urandom), 1'($urandom), "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule